// File: doc/BRIEF.md
# MMU Access Control Trap Checker

This block judges every memory access that passes through a page-based memory management unit. It takes the access kind, the three-bit access control code of the selected page descriptor and the outcome of the page length comparison. From these it decides whether the access must be aborted, whether it meets a trap condition, and whether the descriptor's accessed (A) and written (W) status bits should be set. The decision is presented one clock after the request, as registered single-cycle strobes.

The block also holds the writable part of the memory management status register. That register records the reason for an abort and a trap flag, and it holds the trap enable bit. Once any abort reason is recorded, the register is frozen against further hardware updates until software rewrites it. A trap request is raised only when trapping is enabled, the register is not frozen and the access is not aborted. The enable value used is the one in force before any status write in the same cycle, so an instruction that clears the enable and traps in the same cycle still gets its trap.

Top module: `mmu_acf_check`

## Requirements
- R1: While `rst` is high and in the first cycle after it, all strobes (`abort_o`, `trap_o`, `set_a_o`, `set_w_o`) are 0 and `status_o` is 0.
- R2: Access codes 3'b000, 3'b011 and 3'b111 abort every access as non-resident and record bit 15 of the status register.
- R3: A page length error (`len_err`=1) aborts the access and records status bit 14. It combines with the other abort reasons.
- R4: Codes 3'b001 and 3'b010 are read-only. A write (`acc_kind`=2'b01) or read-modify-write (2'b10 or 2'b11) to them aborts and records status bit 13. A read (2'b00) does not abort.
- R5: The trap condition is met for code 3'b001 on a read, for 3'b100 on any access, and for 3'b101 on a write or read-modify-write. Codes 3'b010 and 3'b110 never meet it.
- R6: `set_a_o` pulses only for an access that is not aborted and meets the trap condition.
- R7: `set_w_o` pulses for every write or read-modify-write access that is not aborted.
- R8: Status bit 12 (trap flag) is set by an access that meets the trap condition and is not aborted, and only while the register is not frozen.
- R9: `trap_o` pulses when status bit 9 (trap enable) was 1 before the cycle of the access, the access meets the trap condition, is not aborted, and no abort bit (15..13) was already set. It still pulses when a status write clears bit 9 in the same cycle.
- R10: While any of status bits 15..13 is set, accesses leave `status_o` unchanged, and only a status write alters it.
- R11: A status write loads `wr_data` masked to bits 15, 14, 13, 12 and 9; all other bits read 0. Updates from an access in the same cycle are then ORed on top, judged against the state before the write.
- R12: All strobes appear exactly one cycle after a request with `req_valid`=1 and are 0 after a cycle without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | An access is presented this cycle |
| acc_kind | input | 2 | 00 read, 01 write, 10/11 read-modify-write |
| acf | input | 3 | Access control code of the selected descriptor |
| len_err | input | 1 | Page length check failed |
| wr_en | input | 1 | Software write to the status register |
| wr_data | input | 16 | Value written to the status register |
| abort_o | output | 1 | Abort request for the access |
| trap_o | output | 1 | Memory management trap request |
| set_a_o | output | 1 | Set the descriptor A bit |
| set_w_o | output | 1 | Set the descriptor W bit |
| status_o | output | 16 | Status register contents |

## Verification
Two functions can fall in the same cycle: a software status write and the hardware update from an access. The most telling case is a write that clears the trap enable while the access meets a trap condition. Directed steps provoke this, and a trap pulse is then required together with a register that shows the written value and the trap flag ORed in. Random traffic also mixes status writes, length errors and every access code with the frozen state. A behavioural reference model judges every strobe and the status value on every clock.

// File: rtl/mmu_acf_pkg.sv
package mmu_acf_pkg;

    localparam int ST_W     = 16;
    localparam int ST_NR    = 15;
    localparam int ST_LEN   = 14;
    localparam int ST_RO    = 13;
    localparam int ST_TRAP  = 12;
    localparam int ST_EN    = 9;

    localparam logic [ST_W-1:0] ST_WR_MASK =
        ST_W'((1 << ST_NR) | (1 << ST_LEN) | (1 << ST_RO) | (1 << ST_TRAP) | (1 << ST_EN));

    typedef enum logic [1:0] {
        ACC_READ  = 2'b00,
        ACC_WRITE = 2'b01,
        ACC_RMW   = 2'b10,
        ACC_RMW_X = 2'b11
    } acc_kind_t;

    typedef struct packed {
        logic nonres;
        logic rd_only;
        logic trap_rd;
        logic trap_wr;
    } acf_attr_t;

    typedef struct packed {
        logic abort;
        logic ab_nr;
        logic ab_len;
        logic ab_ro;
        logic trap_cond;
        logic set_a;
        logic set_w;
    } verdict_t;

    function automatic acf_attr_t decode_acf(input logic [2:0] code);
        acf_attr_t a;
        a = '0;
        case (code)
            3'b001:  begin a.rd_only = 1'b1; a.trap_rd = 1'b1; end
            3'b010:  a.rd_only = 1'b1;
            3'b100:  begin a.trap_rd = 1'b1; a.trap_wr = 1'b1; end
            3'b101:  a.trap_wr = 1'b1;
            3'b110:  a = '0;
            default: a.nonres = 1'b1;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/mmu_acf_judge.sv
module mmu_acf_judge
    import mmu_acf_pkg::*;
(
    input  acc_kind_t  kind,
    input  logic [2:0] acf,
    input  logic       len_err,
    output verdict_t   verdict
);

    acf_attr_t attr;
    logic      is_wr;
    logic      is_rd;

    always_comb begin
        attr              = decode_acf(acf);
        is_wr             = (kind != ACC_READ);
        is_rd             = (kind != ACC_WRITE);
        verdict.ab_nr     = attr.nonres;
        verdict.ab_len    = len_err;
        verdict.ab_ro     = attr.rd_only & is_wr;
        verdict.abort     = verdict.ab_nr | verdict.ab_len | verdict.ab_ro;
        verdict.trap_cond = (attr.trap_rd & is_rd) | (attr.trap_wr & is_wr);
        verdict.set_a     = ~verdict.abort & verdict.trap_cond;
        verdict.set_w     = ~verdict.abort & is_wr;
    end

endmodule

// File: rtl/mmu_stat_reg.sv
module mmu_stat_reg
    import mmu_acf_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [ST_W-1:0] wr_data,
    input  logic            hw_valid,
    input  verdict_t        verdict,
    output logic [ST_W-1:0] status_q,
    output logic            frozen,
    output logic            trap_en
);

    logic [ST_W-1:0] status_d;

    assign frozen  = status_q[ST_NR] | status_q[ST_LEN] | status_q[ST_RO];
    assign trap_en = status_q[ST_EN];

    always_comb begin
        status_d = wr_en ? (wr_data & ST_WR_MASK) : status_q;
        if (hw_valid && !frozen) begin
            status_d[ST_NR]   = status_d[ST_NR]   | verdict.ab_nr;
            status_d[ST_LEN]  = status_d[ST_LEN]  | verdict.ab_len;
            status_d[ST_RO]   = status_d[ST_RO]   | verdict.ab_ro;
            status_d[ST_TRAP] = status_d[ST_TRAP] | (verdict.trap_cond & ~verdict.abort);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) status_q <= '0;
        else     status_q <= status_d;
    end

endmodule

// File: rtl/mmu_acf_check.sv
module mmu_acf_check
    import mmu_acf_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    input  logic [1:0]      acc_kind,
    input  logic [2:0]      acf,
    input  logic            len_err,
    input  logic            wr_en,
    input  logic [ST_W-1:0] wr_data,
    output logic            abort_o,
    output logic            trap_o,
    output logic            set_a_o,
    output logic            set_w_o,
    output logic [ST_W-1:0] status_o
);

    verdict_t verdict;
    logic     frozen;
    logic     trap_en;

    mmu_acf_judge judge_i (
        .kind    (acc_kind_t'(acc_kind)),
        .acf     (acf),
        .len_err (len_err),
        .verdict (verdict)
    );

    mmu_stat_reg stat_i (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .hw_valid (req_valid),
        .verdict  (verdict),
        .status_q (status_o),
        .frozen   (frozen),
        .trap_en  (trap_en)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            abort_o <= 1'b0;
            trap_o  <= 1'b0;
            set_a_o <= 1'b0;
            set_w_o <= 1'b0;
        end else begin
            abort_o <= req_valid & verdict.abort;
            trap_o  <= req_valid & trap_en & ~frozen & verdict.trap_cond & ~verdict.abort;
            set_a_o <= req_valid & verdict.set_a;
            set_w_o <= req_valid & verdict.set_w;
        end
    end

endmodule

// File: rtl/mmu_acf_check_sva.sv
module mmu_acf_check_sva (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        wr_en,
    input logic        abort_o,
    input logic        trap_o,
    input logic        set_a_o,
    input logic        set_w_o,
    input logic [15:0] status_o
);

    a_r6_a_not_on_abort: assert property (@(posedge clk) disable iff (rst)
        set_a_o |-> !abort_o);

    a_r7_w_not_on_abort: assert property (@(posedge clk) disable iff (rst)
        set_w_o |-> !abort_o);

    a_r9_trap_needs_prior_enable: assert property (@(posedge clk) disable iff (rst)
        trap_o |-> ($past(status_o[9]) && !$past(|status_o[15:13]) && !abort_o));

    a_r10_frozen_holds: assert property (@(posedge clk) disable iff (rst)
        ((|status_o[15:13]) && !wr_en) |=> $stable(status_o));

    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!abort_o && !trap_o && !set_a_o && !set_w_o));

    a_r8_flag_not_on_abort: assert property (@(posedge clk) disable iff (rst)
        ($rose(status_o[12]) && !$past(wr_en)) |-> !abort_o);

endmodule

bind mmu_acf_check mmu_acf_check_sva chk_i (.*);

// File: tb/mmu_acf_check_tb_top.sv
module mmu_acf_check_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [1:0]  acc_kind;
    logic [2:0]  acf;
    logic        len_err;
    logic        wr_en;
    logic [15:0] wr_data;
    logic        abort_o, trap_o, set_a_o, set_w_o;
    logic [15:0] status_o;

    int n_cmp = 0;
    int n_bad = 0;

    // expected values of the outputs after the coming clock edge
    bit        e_abort, e_trap, e_a, e_w;
    bit [15:0] e_stat;
    bit [15:0] m_stat;

    always #5 clk = ~clk;

    mmu_acf_check dut_i (.*);

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R2 R3 R4 R12 abort", int'(abort_o), int'(e_abort));
        chk("R5 R9 R12 trap",     int'(trap_o),  int'(e_trap));
        chk("R5 R6 set_a",        int'(set_a_o), int'(e_a));
        chk("R7 set_w",           int'(set_w_o), int'(e_w));
        chk("R1 R8 R10 R11 status", int'(status_o), int'(e_stat));
    endtask

    // Behavioural model of one cycle
    task automatic model(input bit r, input bit v, input int k, input int c,
                         input bit le, input bit we, input bit [15:0] wd);
        bit wr_like, rd_like, nr, ro, tc, ab, fz, en;
        bit [15:0] nxt;
        if (r) begin
            m_stat = 0; e_abort = 0; e_trap = 0; e_a = 0; e_w = 0; e_stat = 0;
            return;
        end
        wr_like = (k != 0);
        rd_like = (k != 1);
        nr = (c == 0) || (c == 3) || (c == 7);
        ro = ((c == 1) || (c == 2)) && wr_like;
        tc = ((c == 1) && rd_like) || (c == 4) || ((c == 5) && wr_like);
        ab = nr || le || ro;
        fz = (m_stat[15] || m_stat[14] || m_stat[13]);
        en = m_stat[9];
        nxt = we ? (wd & 16'hF200) : m_stat;
        if (v && !fz) begin
            if (nr) nxt[15] = 1;
            if (le) nxt[14] = 1;
            if (ro) nxt[13] = 1;
            if (tc && !ab) nxt[12] = 1;
        end
        e_abort = v && ab;
        e_trap  = v && en && !fz && tc && !ab;
        e_a     = v && tc && !ab;
        e_w     = v && wr_like && !ab;
        m_stat  = nxt;
        e_stat  = nxt;
    endtask

    task automatic step(input bit r, input bit v, input int k, input int c,
                        input bit le, input bit we, input bit [15:0] wd);
        @(negedge clk);
        compare_all();
        rst = r; req_valid = v; acc_kind = 2'(k); acf = 3'(c);
        len_err = le; wr_en = we; wr_data = wd;
        model(r, v, k, c, le, we, wd);
    endtask

    initial begin
        #2000000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst = 1; req_valid = 0; acc_kind = 0; acf = 0; len_err = 0; wr_en = 0; wr_data = 0;
        model(1, 0, 0, 0, 0, 0, 0);
        // R1: reset state
        step(1, 1, 1, 0, 1, 1, 16'hFFFF);
        step(1, 0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0);
        // R11: enable trapping
        step(0, 0, 0, 0, 0, 1, 16'h0200);
        // R5 R9: read of code 001 traps
        step(0, 1, 0, 1, 0, 0, 0);
        // R9: clearing the enable in the same cycle as a trapping access
        step(0, 1, 2, 4, 0, 1, 16'h0000);
        // enable rewritten while write to 101: old enable is 0, no trap
        step(0, 1, 1, 5, 0, 1, 16'h0200);
        // R5: code 110 and read of 010 never trap
        step(0, 1, 1, 6, 0, 0, 0);
        step(0, 1, 0, 2, 0, 0, 0);
        // R3: length error with trapping code
        step(0, 1, 0, 4, 1, 0, 0);
        // R10: frozen, trapping access leaves status alone
        step(0, 1, 0, 4, 0, 0, 0);
        step(0, 1, 1, 3, 0, 0, 0);
        // R11: software clears, then R4 read-only violation via rmw
        step(0, 0, 0, 0, 0, 1, 16'h0200);
        step(0, 1, 3, 1, 0, 0, 0);
        step(0, 0, 0, 0, 0, 1, 16'hFFFF);
        step(0, 0, 0, 0, 0, 1, 16'h0200);
        // R2: codes 000 and 111 with length error together
        step(0, 1, 0, 7, 1, 0, 0);
        step(0, 0, 0, 0, 0, 1, 16'h0200);
        step(0, 1, 1, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0);
        // random traffic
        for (int i = 0; i < 4000; i++) begin
            int sel;
            bit [15:0] wd;
            sel = $urandom_range(0, 3);
            wd = (sel == 0) ? 16'h0200 : (sel == 1) ? 16'h0000 :
                 (sel == 2) ? 16'h1200 : 16'($urandom);
            step(($urandom_range(0, 199) == 0),
                 ($urandom_range(0, 3) != 0),
                 $urandom_range(0, 3),
                 $urandom_range(0, 7),
                 ($urandom_range(0, 7) == 0),
                 ($urandom_range(0, 5) == 0),
                 wd);
        end
        @(negedge clk);
        compare_all();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule